// File: doc/BRIEF.md
# Audio Auto-Mute Detector

This block watches a stereo stream of signed audio samples, one pair per valid strobe, and silences a channel once that channel has carried a long unbroken run of static samples. A sample counts as static when every bit is clear (zero) or every bit is set (minus one). The run has to stay at one of those two values. A change from one static value to the other starts a new run.

Each channel has a mute flag that can drive a mute-control pin. While a channel is muted, its sample word is forced to zero at the output. The first non-static sample lifts the mute on the same sample and passes through unchanged. When gang mode is on, the two channels mute and unmute together.

The mute is a hard gate applied at a sample boundary. Every output is registered, so it appears one clock after the strobe that carried the sample. The auto-mute enable is meant to be driven high out of reset, which makes detection active by default.

Top module: `automute_gate`

## Requirements
- R1: After reset, `mute_a`, `mute_b` and `out_vld` are low and `out_a`, `out_b` are zero.
- R2: A channel's mute flag is high on the output cycle of the RUN_LEN-th consecutive equal static sample on that channel. Static means all bits zero or all bits one.
- R3: A run of RUN_LEN-1 equal static samples leaves the channel unmuted.
- R4: A change between zero and all-ones restarts the run at 1. Mute then follows RUN_LEN-1 further samples of the new value.
- R5: A non-static sample clears the channel's mute on that sample's own output cycle, passes the sample unchanged, and restarts the run count.
- R6: While a channel is muted, its output word is zero, even when the input is all-ones.
- R7: With `gang_en` low, each channel mutes on its own run, regardless of the other channel.
- R8: With `gang_en` high, both channels mute only when both runs have reached RUN_LEN, and a non-static sample on either channel releases both.
- R9: With `amute_en` low, both mute flags clear on the next clock, the run counters are held at zero, and samples pass unchanged. Once the enable returns, a full new run is needed.
- R10: The run counter saturates at RUN_LEN, so a run longer than RUN_LEN keeps the channel muted without wrapping.
- R11: Samples with `smp_vld` low are ignored. `out_vld` is `smp_vld` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample pair strobe |
| smp_a | input | DATA_W | Channel A sample, signed |
| smp_b | input | DATA_W | Channel B sample, signed |
| amute_en | input | 1 | Auto-mute enable |
| gang_en | input | 1 | Couple both channels' muting |
| mute_a | output | 1 | Channel A mute-control flag |
| mute_b | output | 1 | Channel B mute-control flag |
| out_vld | output | 1 | Output sample strobe |
| out_a | output | DATA_W | Channel A sample, zero while muted |
| out_b | output | DATA_W | Channel B sample, zero while muted |

## Verification
The bench drives runs of zeros and of all-ones, stopping at one sample short of the limit and at exactly the limit. This separates an off-by-one in the run length from a correct threshold, and all-ones input shows that muted words are forced to zero rather than passed through. A zero-to-all-ones switch mid-run checks that a mixed static run does not count as one run. An over-long run checks that the counter saturates instead of wrapping. Runs that differ between the channels are then played with gang mode off and on, telling independent muting apart from coupled muting and coupled release. A run broken by disabling and re-enabling shows that the enable resets detection.

// File: rtl/automute_gate.sv
module automute_gate #(
  parameter int DATA_W  = 24,
  parameter int RUN_LEN = 8192
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_vld,
  input  logic signed [DATA_W-1:0] smp_a,
  input  logic signed [DATA_W-1:0] smp_b,
  input  logic                     amute_en,
  input  logic                     gang_en,
  output logic                     mute_a,
  output logic                     mute_b,
  output logic                     out_vld,
  output logic signed [DATA_W-1:0] out_a,
  output logic signed [DATA_W-1:0] out_b
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(RUN_LEN);
  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  logic [CW-1:0]     cnt_a, cnt_b, nxt_a, nxt_b;
  logic [DATA_W-1:0] last_a, last_b;
  logic              st_a, st_b, full_a, full_b, mn_a, mn_b;

  function automatic logic [CW-1:0] step(input logic [CW-1:0] c,
                                         input logic [DATA_W-1:0] x,
                                         input logic [DATA_W-1:0] prev,
                                         input logic st);
    if (!st)                       return '0;
    else if (c != '0 && x == prev) return (c == LIMIT) ? c : c + 1'b1;
    else                           return CW'(1);
  endfunction

  assign st_a   = (smp_a == '0) || (smp_a == ONES);
  assign st_b   = (smp_b == '0) || (smp_b == ONES);
  assign nxt_a  = step(cnt_a, smp_a, last_a, st_a);
  assign nxt_b  = step(cnt_b, smp_b, last_b, st_b);
  assign full_a = (nxt_a == LIMIT);
  assign full_b = (nxt_b == LIMIT);
  assign mn_a   = gang_en ? (full_a && full_b) : full_a;
  assign mn_b   = gang_en ? (full_a && full_b) : full_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_a <= '0; cnt_b <= '0; last_a <= '0; last_b <= '0;
      mute_a <= 1'b0; mute_b <= 1'b0; out_vld <= 1'b0;
      out_a <= '0; out_b <= '0;
    end else begin
      out_vld <= smp_vld;
      if (!amute_en) begin
        cnt_a <= '0; cnt_b <= '0;
        mute_a <= 1'b0; mute_b <= 1'b0;
        if (smp_vld) begin
          out_a <= smp_a; out_b <= smp_b;
          last_a <= smp_a; last_b <= smp_b;
        end
      end else if (smp_vld) begin
        cnt_a <= nxt_a; cnt_b <= nxt_b;
        last_a <= smp_a; last_b <= smp_b;
        mute_a <= mn_a; mute_b <= mn_b;
        out_a <= mn_a ? '0 : smp_a;
        out_b <= mn_b ? '0 : smp_b;
      end
    end
  end

  a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_a <= LIMIT && cnt_b <= LIMIT);
  a_r6_zero_when_muted: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && mute_a) |-> out_a == '0);
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && amute_en && !st_a && !st_b) |=> (!mute_a && !mute_b));
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !amute_en |=> (!mute_a && !mute_b && cnt_a == '0 && cnt_b == '0));
  a_r8_gang_same: assert property (@(posedge clk) disable iff (!rst_n)
    (gang_en && smp_vld) |=> mute_a == mute_b);
  a_r2_mute_on_static: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute_a) |-> $past(st_a && smp_vld));
endmodule

// File: tb/automute_gate_tb_top.sv
module automute_gate_tb_top;
  localparam int W = 16;
  localparam int N = 64;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0, smp_vld = 1'b0, amute_en = 1'b1, gang_en = 1'b0;
  logic signed [W-1:0] smp_a = '0, smp_b = '0;
  logic mute_a, mute_b, out_vld;
  logic signed [W-1:0] out_a, out_b;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  automute_gate #(.DATA_W(W), .RUN_LEN(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_a(smp_a), .smp_b(smp_b),
    .amute_en(amute_en), .gang_en(gang_en), .mute_a(mute_a), .mute_b(mute_b),
    .out_vld(out_vld), .out_a(out_a), .out_b(out_b));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [W-1:0] a, input logic [W-1:0] b);
    smp_vld = 1'b1; smp_a = a; smp_b = b;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input int n);
    for (int i = 0; i < n; i++) push(a, b);
  endtask

  task automatic clean();
    gang_en = 1'b0;
    push(16'sd5, 16'sd7);
  endtask

  task automatic t_reset();
    chk(!mute_a && !mute_b && !out_vld && out_a == 0 && out_b == 0, "R1", {mute_a, mute_b, out_vld}, 0);
  endtask

  task automatic t_threshold();
    run('0, 16'sd3, N - 1);
    chk(!mute_a, "R3", mute_a, 0);
    chk(out_vld, "R11", out_vld, 1);
    push('0, 16'sd3);
    chk(mute_a && out_a == 0, "R2", mute_a, 1);
    chk(!mute_b, "R7", mute_b, 0);
    push(16'sd100, 16'sd3);
    chk(!mute_a && out_a == 100, "R5", out_a, 100);
    run('0, 16'sd3, N - 1);
    chk(!mute_a, "R5 restart", mute_a, 0);
    clean();
  endtask

  task automatic t_ones_gap();
    for (int i = 0; i < N; i++) begin
      push(ONES, 16'sd1);
      if (i == N / 2) begin
        @(negedge clk); @(negedge clk);
        chk(!out_vld, "R11 gap", out_vld, 0);
      end
    end
    chk(mute_a && out_a == 0, "R6", out_a, 0);
    clean();
  endtask

  task automatic t_flip();
    run('0, 16'sd1, N - 1);
    run(ONES, 16'sd1, N - 1);
    chk(!mute_a, "R4", mute_a, 0);
    push(ONES, 16'sd1);
    chk(mute_a, "R4 full", mute_a, 1);
    clean();
  endtask

  task automatic t_saturate();
    run('0, 16'sd1, 3 * N + 5);
    chk(mute_a, "R10", mute_a, 1);
    clean();
  endtask

  task automatic t_indep();
    run(16'sd9, '0, 4);
    run('0, '0, N - 4);
    chk(mute_b && !mute_a, "R7", {mute_a, mute_b}, 1);
    clean();
  endtask

  task automatic t_gang();
    gang_en = 1'b1;
    run(16'sd9, '0, 4);
    run('0, '0, N - 4);
    chk(!mute_a && !mute_b, "R8 wait", {mute_a, mute_b}, 0);
    run('0, '0, 4);
    chk(mute_a && mute_b && out_a == 0 && out_b == 0, "R8 both", {mute_a, mute_b}, 3);
    push('0, 16'sd42);
    chk(!mute_a && !mute_b && out_b == 42, "R8 release", {mute_a, mute_b}, 0);
    clean();
  endtask

  task automatic t_enable();
    run('0, '0, N);
    chk(mute_a && mute_b, "R9 pre", {mute_a, mute_b}, 3);
    amute_en = 1'b0;
    @(negedge clk);
    chk(!mute_a && !mute_b, "R9 clear", {mute_a, mute_b}, 0);
    push(ONES, '0);
    chk(out_a == -1 && !mute_a, "R9 pass", out_a, -1);
    amute_en = 1'b1;
    run('0, '0, N - 1);
    chk(!mute_a && !mute_b, "R9 fresh", {mute_a, mute_b}, 0);
    push('0, '0);
    chk(mute_a && mute_b, "R9 remute", {mute_a, mute_b}, 3);
    clean();
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_ones_gap();
    t_flip();
    t_saturate();
    t_indep();
    t_gang();
    t_enable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule